// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

This block moves data between an A bus and a B bus in either direction. The bus is split into independent groups; the default is two groups of eight bits. Each group has its own A-to-B and B-to-A controls. Every direction of every group has one storage element. With its pass control high, the element is transparent. With its pass control low, the output shows the value taken at the most recent rising edge of the shared clock. A single global off control removes every driver in both directions. An active-low enable per direction and group decides which side drives when the global off is low. The A side has a bus keeper, so a line that nobody drives presents its last valid level.

The pads sit outside the block. Each bus is therefore carried as separate input value, output value and output-enable vectors, and the pad ring resolves them into the physical tri-state lines. On the A side an extra input tells the block which lines an outside agent is driving, which lets the keeper decide where to hold.

Top module: `bus_xcvr_top`

## Requirements
- R1: While a group's A-to-B pass control is 1, that group's b_out bits equal the resolved A line level of the same bits within the same cycle.
- R2: While a group's A-to-B pass control is 0, that group's b_out bits equal the A line level captured at the most recent rising clock edge. Changes on A between edges do not reach b_out.
- R3: When the A-to-B pass control falls between two edges, b_out shows the value captured at the last rising edge before the fall, not the A level at the moment of the fall.
- R4: The storage elements load at every rising edge whatever the output enables are, so a value captured while the outputs are off appears once they are enabled.
- R5: The B-to-A path follows R1 to R3 with its own pass control, taking b_in as its source and driving a_out.
- R6: With global off at 0, a group's b_oe bits are all 1 exactly when that group's A-to-B enable (active low) is 0. Likewise, its a_oe bits are all 1 exactly when its B-to-A enable (active low) is 0.
- R7: With global off at 1, every a_oe and b_oe bit is 0, whatever the per-direction enables are.
- R8: Group g controls bits [g*GRP_W +: GRP_W] only. Its controls have no effect on the other groups' outputs.
- R9: The resolved A line level of a bit is a_in when a_in_drv is 1. It is a_out when the block itself drives that bit. Otherwise it is the level that bit had at the last rising edge (bus keeper).
- R10: A synchronous active-high reset clears every storage element and the keeper to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared capture clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| all_off | input | 1 | Global off: 1 removes every driver on both buses |
| ab_en_n | input | NUM_GRP | Per-group A-to-B output enable, active low |
| ba_en_n | input | NUM_GRP | Per-group B-to-A output enable, active low |
| ab_pass | input | NUM_GRP | Per-group A-to-B pass control: 1 transparent, 0 clocked/hold |
| ba_pass | input | NUM_GRP | Per-group B-to-A pass control: 1 transparent, 0 clocked/hold |
| a_in | input | BUS_W | Level applied to the A lines from outside |
| a_in_drv | input | BUS_W | Per bit: 1 when an outside agent drives that A line |
| a_out | output | BUS_W | Value the block drives onto the A lines |
| a_oe | output | BUS_W | Per bit A-side driver enable |
| b_in | input | BUS_W | Level on the B lines |
| b_out | output | BUS_W | Value the block drives onto the B lines |
| b_oe | output | BUS_W | Per bit B-side driver enable |

## Verification
The bench builds the block with its defaults, two groups of eight bits. Two groups are enough to show group independence, because one group can be transparent while the other holds, and the two can have different enables. Eight bits per group give random data patterns wide enough that a stale or swapped slice is unlikely to match by chance. Random cycles change the data twice between edges, which exercises the difference between transparent and clocked output at every step. Directed phases cover the pass-control fall, capture while the outputs are off, keeper hold and the post-reset state.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int DEF_GRP_W   = 8;
    localparam int DEF_NUM_GRP = 2;

    // control bundle for one direction of one group
    typedef struct packed {
        logic en_n;   // output enable, active low
        logic pass;   // 1: transparent, 0: clocked / hold
    } dir_ctl_t;

    // a direction drives only when the global off is low and its own enable is low
    function automatic logic drive_on(input logic off, input dir_ctl_t ctl);
        return !off && !ctl.en_n;
    endfunction
endpackage

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int W = DEF_GRP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         all_off,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         drv
);
    logic [W-1:0] store;

    // storage loads on every rising edge, independent of the output enable
    always_ff @(posedge clk) begin
        if (rst) store <= '0;
        else     store <= d;
    end

    always_comb begin
        q   = ctl.pass ? d : store;
        drv = drive_on(all_off, ctl);
    end

    // R2
    hold_value_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.pass && !$past(rst)) |-> (q == $past(d)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        ($past(rst) && !ctl.pass) |-> (q == '0));
endmodule

// File: rtl/a_keeper.sv
module a_keeper #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ext_drv,
    input  logic [W-1:0] ext_val,
    input  logic [W-1:0] own_drv,
    input  logic [W-1:0] own_val,
    output logic [W-1:0] line
);
    logic [W-1:0] held;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (ext_drv[i])      line[i] = ext_val[i];
            else if (own_drv[i]) line[i] = own_val[i];
            else                 line[i] = held[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) held <= '0;
        else     held <= line;
    end

    // R9
    keeper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (((line ^ $past(line)) & ~ext_drv & ~own_drv) == '0));
endmodule

// File: rtl/bus_xcvr_top.sv
module bus_xcvr_top
    import xcvr_pkg::*;
#(
    parameter int GRP_W   = DEF_GRP_W,
    parameter int NUM_GRP = DEF_NUM_GRP,
    localparam int BUS_W  = GRP_W * NUM_GRP
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               all_off,
    input  logic [NUM_GRP-1:0] ab_en_n,
    input  logic [NUM_GRP-1:0] ba_en_n,
    input  logic [NUM_GRP-1:0] ab_pass,
    input  logic [NUM_GRP-1:0] ba_pass,
    input  logic [BUS_W-1:0]   a_in,
    input  logic [BUS_W-1:0]   a_in_drv,
    output logic [BUS_W-1:0]   a_out,
    output logic [BUS_W-1:0]   a_oe,
    input  logic [BUS_W-1:0]   b_in,
    output logic [BUS_W-1:0]   b_out,
    output logic [BUS_W-1:0]   b_oe
);
    logic [BUS_W-1:0] a_line;

    a_keeper #(.W(BUS_W)) u_keeper (
        .clk     (clk),
        .rst     (rst),
        .ext_drv (a_in_drv),
        .ext_val (a_in),
        .own_drv (a_oe),
        .own_val (a_out),
        .line    (a_line)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int LO = g * GRP_W;
        dir_ctl_t ab_ctl, ba_ctl;
        logic     ab_drv, ba_drv;

        assign ab_ctl = '{en_n: ab_en_n[g], pass: ab_pass[g]};
        assign ba_ctl = '{en_n: ba_en_n[g], pass: ba_pass[g]};

        xcvr_path #(.W(GRP_W)) u_ab (
            .clk     (clk),
            .rst     (rst),
            .all_off (all_off),
            .ctl     (ab_ctl),
            .d       (a_line[LO +: GRP_W]),
            .q       (b_out[LO +: GRP_W]),
            .drv     (ab_drv)
        );

        xcvr_path #(.W(GRP_W)) u_ba (
            .clk     (clk),
            .rst     (rst),
            .all_off (all_off),
            .ctl     (ba_ctl),
            .d       (b_in[LO +: GRP_W]),
            .q       (a_out[LO +: GRP_W]),
            .drv     (ba_drv)
        );

        assign b_oe[LO +: GRP_W] = {GRP_W{ab_drv}};
        assign a_oe[LO +: GRP_W] = {GRP_W{ba_drv}};

        // R6
        grp_enable_chk: assert property (@(posedge clk) disable iff (rst)
            (!all_off && !ab_en_n[g]) |-> (&b_oe[LO +: GRP_W]));
    end

    // R7
    global_off_chk: assert property (@(posedge clk) disable iff (rst)
        all_off |-> (a_oe == '0 && b_oe == '0));
endmodule

// File: tb/test_bus_xcvr_top.sv
`timescale 1ns/1ps
module test_bus_xcvr_top;
    localparam int GW = 8;
    localparam int NG = 2;
    localparam int BW = GW * NG;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          all_off = 1'b0;
    logic [NG-1:0] ab_en_n = '1, ba_en_n = '1, ab_pass = '0, ba_pass = '0;
    logic [BW-1:0] a_in = '0, a_in_drv = '1, b_in = '0;
    logic [BW-1:0] a_out, a_oe, b_out, b_oe;

    int checks = 0;
    int errors = 0;

    bus_xcvr_top #(.GRP_W(GW), .NUM_GRP(NG)) i_bus_xcvr_top (
        .clk(clk), .rst(rst), .all_off(all_off),
        .ab_en_n(ab_en_n), .ba_en_n(ba_en_n),
        .ab_pass(ab_pass), .ba_pass(ba_pass),
        .a_in(a_in), .a_in_drv(a_in_drv), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    always #5 clk = ~clk;

    // reference state, built from the requirements
    logic [BW-1:0] m_ab, m_ba, m_keep;

    function automatic logic [BW-1:0] exp_aoe();
        logic [BW-1:0] m = '0;
        for (int g = 0; g < NG; g++)
            if (!all_off && !ba_en_n[g]) m[g*GW +: GW] = '1;
        return m;
    endfunction

    function automatic logic [BW-1:0] exp_boe();
        logic [BW-1:0] m = '0;
        for (int g = 0; g < NG; g++)
            if (!all_off && !ab_en_n[g]) m[g*GW +: GW] = '1;
        return m;
    endfunction

    function automatic logic [BW-1:0] exp_aout();
        logic [BW-1:0] v;
        for (int g = 0; g < NG; g++)
            v[g*GW +: GW] = ba_pass[g] ? b_in[g*GW +: GW] : m_ba[g*GW +: GW];
        return v;
    endfunction

    function automatic logic [BW-1:0] exp_line();
        logic [BW-1:0] own = exp_aoe();
        logic [BW-1:0] ov  = exp_aout();
        logic [BW-1:0] v;
        for (int i = 0; i < BW; i++)
            v[i] = a_in_drv[i] ? a_in[i] : (own[i] ? ov[i] : m_keep[i]);
        return v;
    endfunction

    function automatic logic [BW-1:0] exp_bout();
        logic [BW-1:0] ln = exp_line();
        logic [BW-1:0] v;
        for (int g = 0; g < NG; g++)
            v[g*GW +: GW] = ab_pass[g] ? ln[g*GW +: GW] : m_ab[g*GW +: GW];
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ab <= '0; m_ba <= '0; m_keep <= '0;
        end else begin
            m_ab <= exp_line(); m_ba <= b_in; m_keep <= exp_line();
        end
    end

    task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [BW-1:0] eb = exp_bout();
        logic [BW-1:0] ea = exp_aout();
        logic [BW-1:0] ebo = exp_boe();
        logic [BW-1:0] eao = exp_aoe();
        for (int g = 0; g < NG; g++) begin
            chk(ab_pass[g] ? "R1 group b_out" : "R2 group b_out",
                {{(BW-GW){1'b0}}, b_out[g*GW +: GW]}, {{(BW-GW){1'b0}}, eb[g*GW +: GW]});
            chk("R5 group a_out",
                {{(BW-GW){1'b0}}, a_out[g*GW +: GW]}, {{(BW-GW){1'b0}}, ea[g*GW +: GW]});
        end
        chk(all_off ? "R7 b_oe" : "R6 b_oe", b_oe, ebo);
        chk(all_off ? "R7 a_oe" : "R6 a_oe", a_oe, eao);
    endtask

    task automatic randomize_ctl();
        all_off = ($urandom_range(7) == 0);
        ab_en_n = NG'($urandom);
        ba_en_n = NG'($urandom);
        for (int g = 0; g < NG; g++)
            if (!ab_en_n[g] && !ba_en_n[g]) begin
                if ($urandom_range(1) == 1) ab_en_n[g] = 1'b1;
                else                        ba_en_n[g] = 1'b1;
            end
        ab_pass = NG'($urandom);
        ba_pass = NG'($urandom);
    endtask

    // watchdog
    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        // R10: reset with data present
        a_in = 16'hFFFF; b_in = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ab_pass = '0; ba_pass = '0;
        #2;
        chk("R10 b_out after reset", b_out, 16'h0000);
        chk("R10 a_out after reset", a_out, 16'h0000);
        chk("R6 outputs off after reset", a_oe | b_oe, 16'h0000);
        a_in_drv = '0; ab_pass = '1;
        #1;
        chk("R10 keeper after reset", b_out, 16'h0000);
        a_in_drv = '1;

        // R3: pass falls between edges
        @(negedge clk);
        ab_pass = '1; ab_en_n = '0; ba_en_n = '1; all_off = 1'b0;
        a_in = 16'hA5C3;
        @(posedge clk);
        #1 a_in = 16'h3C5A;
        #1 chk("R1 transparent follow", b_out, 16'h3C5A);
        ab_pass = '0;
        #1 chk("R3 hold after pass fall", b_out, 16'hA5C3);

        // R4: capture while outputs are off
        @(negedge clk);
        ab_en_n = '1; a_in = 16'h1234;
        @(posedge clk);
        #1 a_in = 16'h0000; ab_en_n = '0;
        #1 chk("R4 captured while off", b_out, 16'h1234);
        chk("R6 enable on", b_oe, 16'hFFFF);

        // R8: group 0 transparent, group 1 holding
        @(negedge clk);
        ab_pass = 2'b01; a_in = 16'h7788;
        @(posedge clk);
        #1 a_in = 16'h99AA;
        #1 chk("R8 group1 holds", {8'h00, b_out[15:8]}, 16'h0077);
        chk("R8 group0 follows", {8'h00, b_out[7:0]}, 16'h00AA);

        // R7: global off overrides
        all_off = 1'b1; ab_en_n = '0; ba_en_n = 2'b11;
        #1 chk("R7 global off b", b_oe, 16'h0000);
        ab_en_n = 2'b11; ba_en_n = '0;
        #1 chk("R7 global off a", a_oe, 16'h0000);
        all_off = 1'b0; ba_en_n = '1;

        // R9: keeper holds a released line
        @(negedge clk);
        a_in_drv = '1; a_in = 16'hBEEF;
        @(posedge clk);
        #1 a_in_drv = '0; a_in = 16'h0000; ab_pass = '1;
        #1 chk("R9 keeper holds", b_out, 16'hBEEF);
        repeat (2) @(posedge clk);
        #1 chk("R9 keeper holds over edges", b_out, 16'hBEEF);

        // R5: B-to-A directed
        @(negedge clk);
        ab_en_n = '1; ba_en_n = '0; ba_pass = '0; b_in = 16'h5A5A;
        @(posedge clk);
        #1 b_in = 16'hC0DE;
        #1 chk("R5 b-to-a holds", a_out, 16'h5A5A);
        ba_pass = '1;
        #1 chk("R5 b-to-a transparent", a_out, 16'hC0DE);
        chk("R9 own drive on line", b_out, 16'hC0DE);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            randomize_ctl();
            a_in     = BW'($urandom);
            b_in     = BW'($urandom);
            a_in_drv = ($urandom_range(3) == 0) ? BW'($urandom) : '1;
            #1 check_all();
            a_in = BW'($urandom);
            b_in = BW'($urandom);
            #1 check_all();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule